// File: doc/BRIEF.md
# Selectable Clock Gate Controller

This block gates one clock and is controlled through a single 32-bit register. Depending on a build-time kind, the gate is driven by a hardware demand input, by a software enable bit, or by either one, with a select bit in the register choosing the owner. A read-only status bit reports whether the gate is actually open. It changes a fixed number of source-clock edges after the gate itself, so software can poll it until a change has finished.

Five kinds come from the same RTL. An ungated kind runs its clock at all times. A hardware-only kind follows the demand input. A software-only kind follows the enable bit. A selectable kind follows either the demand input or the enable bit. A kind that is hardware-or-forced-on follows the demand input while hardware owns it and stays open while software owns it. The output clock comes from a latch-based gating cell. The enable is captured while the source clock is low.

Top module: `clk_gate_ctrl`

Register layout: bit 0 is the enable (1 = open under software control). Bit 1 is the owner select (1 = software, 0 = hardware). Bit 2 is the read-only status (1 = gate open). The kind codes are 0 none, 1 hardware-only, 2 software-only, 3 selectable, 4 hardware-or-forced-on.

## Requirements
- R1: Kind none: the gated clock pulses on every source-clock edge after reset, and the register reads 0 after any write.
- R2: Kind hardware-only: the gate opens while `hw_req_i` is 1 and closes while it is 0. After settling, the register reads 4 when open and 0 when closed.
- R3: Kind software-only: the gate follows bit 0 of the last write. After settling, the register reads 5 when open and 0 when closed.
- R4: Kind selectable: with bit 1 set, the gate follows bit 0 and ignores `hw_req_i`. With bit 1 clear, the gate follows `hw_req_i` and ignores bit 0.
- R5: Kind hardware-or-forced-on: with bit 1 set, the gate stays open whatever `hw_req_i` is. With bit 1 clear, the gate follows `hw_req_i`. This kind has no enable bit.
- R6: After reset, a gate whose enable bit exists reads that bit as 1. A gate that starts under software control is open once reset is released. The status bit reads 0 during reset.
- R7: The status bit equals the gate-open state as it was two source-clock edges earlier. After a write that opens the gate, status first reads 1 after the second rising edge that follows the write edge.
- R8: Written bits that do not exist for the configured kind are dropped and read as 0. Bits 31 to 3 always read as 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Source clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| hw_req_i | input | 1 | Hardware clock demand (1 = clock needed) |
| reg_we_i | input | 1 | Register write strobe, sampled on the rising edge |
| reg_wdata_i | input | 32 | Register write data |
| reg_rdata_o | output | 32 | Register read data: enable, owner select, status |
| gclk_o | output | 1 | Gated clock |

## Verification
The selectable kind is driven through a table of writes, each paired with a level on `hw_req_i`. The table covers software ownership with the enable on and off, hardware ownership with demand on and off, a set enable bit under hardware ownership, and all-ones and all-but-low-bits write data. These rows tell apart the two ownership paths and show which input each one ignores. The other kinds get directed cases that separate the demand-driven path from the forced-open path and from the always-running path. The gate is judged by counting gated-clock pulses over a window. A cycle-by-cycle poll of the status bit after an opening write separates the status lag from the gate's own timing.

// File: rtl/clk_gate_pkg.sv
package clk_gate_pkg;

  typedef enum logic [2:0] {
    GATE_NONE     = 3'd0,
    GATE_HW_ONLY  = 3'd1,
    GATE_SW_ONLY  = 3'd2,
    GATE_SELECT   = 3'd3,
    GATE_HW_OR_ON = 3'd4
  } gate_kind_e;

  localparam int unsigned EN_BIT   = 0;
  localparam int unsigned SEL_BIT  = 1;
  localparam int unsigned STAT_BIT = 2;

  function automatic logic has_en(gate_kind_e k);
    return (k == GATE_SW_ONLY) || (k == GATE_SELECT);
  endfunction

  function automatic logic has_sel(gate_kind_e k);
    return (k == GATE_SELECT) || (k == GATE_HW_OR_ON);
  endfunction

  function automatic logic has_stat(gate_kind_e k);
    return k != GATE_NONE;
  endfunction

endpackage

// File: rtl/gate_ctrl_reg.sv
module gate_ctrl_reg
  import clk_gate_pkg::*;
#(
  parameter gate_kind_e  KIND     = GATE_SELECT,
  parameter int unsigned DATA_W   = 32,
  parameter bit          RESET_SW = 1'b1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              we_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic              hw_req_i,
  output logic [DATA_W-1:0] ctrl_o,
  output logic              req_o
);

  localparam logic [DATA_W-1:0] WR_MASK =
    (DATA_W'(has_en(KIND))  << EN_BIT) |
    (DATA_W'(has_sel(KIND)) << SEL_BIT);
  // enable resets set where it exists; select resets to the configured owner
  localparam logic [DATA_W-1:0] RST_VAL =
    (DATA_W'(has_en(KIND))               << EN_BIT) |
    (DATA_W'(has_sel(KIND) && RESET_SW)  << SEL_BIT);

  logic [DATA_W-1:0] ctrl_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   ctrl_q <= RST_VAL;
    else if (we_i) ctrl_q <= wdata_i & WR_MASK;
  end

  assign ctrl_o = ctrl_q;

  generate
    if (KIND == GATE_NONE) begin : g_none
      assign req_o = 1'b1;
    end else if (KIND == GATE_HW_ONLY) begin : g_hw
      assign req_o = hw_req_i;
    end else if (KIND == GATE_SW_ONLY) begin : g_sw
      assign req_o = ctrl_q[EN_BIT];
    end else if (KIND == GATE_SELECT) begin : g_sel
      assign req_o = ctrl_q[SEL_BIT] ? ctrl_q[EN_BIT] : hw_req_i;
    end else begin : g_hw_or_on
      assign req_o = ctrl_q[SEL_BIT] | hw_req_i;
    end
  endgenerate

endmodule

// File: rtl/gate_status_pipe.sv
module gate_status_pipe #(
  parameter int unsigned LAG = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic d_i,
  output logic q_o
);

  logic [LAG-1:0] stage_q;

  generate
    for (genvar i = 0; i < LAG; i++) begin : g_stage
      if (i == 0) begin : g_first
        always_ff @(posedge clk_i or negedge rst_ni) begin
          if (!rst_ni) stage_q[i] <= 1'b0;
          else         stage_q[i] <= d_i;
        end
      end else begin : g_next
        always_ff @(posedge clk_i or negedge rst_ni) begin
          if (!rst_ni) stage_q[i] <= 1'b0;
          else         stage_q[i] <= stage_q[i-1];
        end
      end
    end
  endgenerate

  assign q_o = stage_q[LAG-1];

endmodule

// File: rtl/gate_cell.sv
module gate_cell (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic req_i,
  output logic open_o,
  output logic gclk_o
);

  logic en_lat;

  // transparent in the low phase so the enable is stable across the high phase
  always_latch begin
    if (!rst_ni)     en_lat = 1'b0;
    else if (!clk_i) en_lat = req_i;
  end

  assign open_o = en_lat;
  assign gclk_o = clk_i & en_lat;

endmodule

// File: rtl/clk_gate_ctrl.sv
module clk_gate_ctrl
  import clk_gate_pkg::*;
#(
  parameter gate_kind_e  KIND       = GATE_SELECT,
  parameter int unsigned DATA_W     = 32,
  parameter int unsigned STATUS_LAG = 2,
  parameter bit          RESET_SW   = 1'b1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              hw_req_i,
  input  logic              reg_we_i,
  input  logic [DATA_W-1:0] reg_wdata_i,
  output logic [DATA_W-1:0] reg_rdata_o,
  output logic              gclk_o
);

  localparam logic [DATA_W-1:0] STAT_MASK = DATA_W'(has_stat(KIND)) << STAT_BIT;

  logic [DATA_W-1:0] ctrl;
  logic              req;
  logic              gate_open;
  logic              status;

  gate_ctrl_reg #(
    .KIND    (KIND),
    .DATA_W  (DATA_W),
    .RESET_SW(RESET_SW)
  ) i_reg (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .we_i    (reg_we_i),
    .wdata_i (reg_wdata_i),
    .hw_req_i(hw_req_i),
    .ctrl_o  (ctrl),
    .req_o   (req)
  );

  gate_cell i_cell (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .req_i (req),
    .open_o(gate_open),
    .gclk_o(gclk_o)
  );

  gate_status_pipe #(
    .LAG(STATUS_LAG)
  ) i_stat (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   (gate_open),
    .q_o   (status)
  );

  assign reg_rdata_o = ctrl | ({DATA_W{status}} & STAT_MASK);

endmodule

// File: rtl/clk_gate_ctrl_chk.sv
module clk_gate_ctrl_chk
  import clk_gate_pkg::*;
#(
  parameter gate_kind_e  KIND       = GATE_SELECT,
  parameter int unsigned DATA_W     = 32,
  parameter int unsigned STATUS_LAG = 2
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              hw_req_i,
  input logic [DATA_W-1:0] reg_rdata_o,
  input logic              gate_open
);

  localparam logic [DATA_W-1:0] LIVE_MASK =
    (DATA_W'(has_en(KIND))   << EN_BIT)  |
    (DATA_W'(has_sel(KIND))  << SEL_BIT) |
    (DATA_W'(has_stat(KIND)) << STAT_BIT);

  logic [1:0] age_q;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)          age_q <= '0;
    else if (age_q != 2'd3) age_q <= age_q + 2'd1;
  end

  // R8: dead bits never read back
  p_dead_bits_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (reg_rdata_o & ~LIVE_MASK) == '0);

  generate
    if (STATUS_LAG == 2) begin : g_lag
      // R7: status is the open state two edges back
      p_status_lag_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (age_q == 2'd3) |-> (reg_rdata_o[STAT_BIT] == $past(gate_open, 2)) || !has_stat(KIND));
    end

    if (KIND == GATE_NONE) begin : g_none
      // R1: ungated clock stays open
      p_always_open_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
        gate_open);
    end else if (KIND == GATE_HW_ONLY) begin : g_hw
      // R2: steady demand decides the gate
      p_hw_follow_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (age_q != 2'd0 && $stable(hw_req_i)) |-> (gate_open == hw_req_i));
    end else if (KIND == GATE_SW_ONLY) begin : g_sw
      // R3: gate tracks the enable bit
      p_sw_follow_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
        gate_open == reg_rdata_o[EN_BIT]);
    end else if (KIND == GATE_SELECT) begin : g_sel
      // R4: software owner uses the enable bit
      p_sel_sw_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
        reg_rdata_o[SEL_BIT] |-> (gate_open == reg_rdata_o[EN_BIT]));
    end else begin : g_hw_or_on
      // R5: software owner forces the gate open
      p_forced_open_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
        reg_rdata_o[SEL_BIT] |-> gate_open);
    end
  endgenerate

endmodule

bind clk_gate_ctrl clk_gate_ctrl_chk #(
  .KIND      (KIND),
  .DATA_W    (DATA_W),
  .STATUS_LAG(STATUS_LAG)
) i_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .hw_req_i   (hw_req_i),
  .reg_rdata_o(reg_rdata_o),
  .gate_open  (gate_open)
);

// File: tb/test_clk_gate_ctrl.sv
module test_clk_gate_ctrl;
  import clk_gate_pkg::*;

  localparam time PERIOD = 10ns;
  localparam int  NVEC   = 7;
  // {wdata[31:0], hw_req, exp_rdata[2:0], running}
  localparam logic [36:0] VEC [NVEC] = '{
    {32'h0000_0003, 1'b0, 3'd7, 1'b1},  // software owner, enable on
    {32'h0000_0002, 1'b1, 3'd2, 1'b0},  // software owner, enable off, demand ignored
    {32'h0000_0000, 1'b1, 3'd4, 1'b1},  // hardware owner, demand on
    {32'h0000_0000, 1'b0, 3'd0, 1'b0},  // hardware owner, demand off
    {32'h0000_0001, 1'b0, 3'd1, 1'b0},  // hardware owner, enable ignored
    {32'hFFFF_FFFF, 1'b0, 3'd7, 1'b1},  // all ones
    {32'hFFFF_FFFC, 1'b1, 3'd4, 1'b1}   // all but low bits
  };

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        hw_req = 1'b0;
  logic        we = 1'b0;
  logic [31:0] wdata = '0;
  logic [31:0] rd_sel, rd_none, rd_hw, rd_sw, rd_hwon;
  logic        g_sel, g_none, g_hw, g_sw, g_hwon;
  int n_chk = 0;
  int n_err = 0;
  int c_sel = 0, c_none = 0, c_hw = 0, c_sw = 0, c_hwon = 0;

  always #(PERIOD/2) clk = ~clk;

  clk_gate_ctrl #(.KIND(GATE_SELECT), .RESET_SW(1'b1)) i_clk_gate_ctrl (
    .clk_i(clk), .rst_ni(rst_n), .hw_req_i(hw_req), .reg_we_i(we),
    .reg_wdata_i(wdata), .reg_rdata_o(rd_sel), .gclk_o(g_sel));
  clk_gate_ctrl #(.KIND(GATE_NONE)) i_clk_gate_ctrl_none (
    .clk_i(clk), .rst_ni(rst_n), .hw_req_i(hw_req), .reg_we_i(we),
    .reg_wdata_i(wdata), .reg_rdata_o(rd_none), .gclk_o(g_none));
  clk_gate_ctrl #(.KIND(GATE_HW_ONLY)) i_clk_gate_ctrl_hw (
    .clk_i(clk), .rst_ni(rst_n), .hw_req_i(hw_req), .reg_we_i(we),
    .reg_wdata_i(wdata), .reg_rdata_o(rd_hw), .gclk_o(g_hw));
  clk_gate_ctrl #(.KIND(GATE_SW_ONLY)) i_clk_gate_ctrl_sw (
    .clk_i(clk), .rst_ni(rst_n), .hw_req_i(hw_req), .reg_we_i(we),
    .reg_wdata_i(wdata), .reg_rdata_o(rd_sw), .gclk_o(g_sw));
  clk_gate_ctrl #(.KIND(GATE_HW_OR_ON), .RESET_SW(1'b0)) i_clk_gate_ctrl_hwon (
    .clk_i(clk), .rst_ni(rst_n), .hw_req_i(hw_req), .reg_we_i(we),
    .reg_wdata_i(wdata), .reg_rdata_o(rd_hwon), .gclk_o(g_hwon));

  always @(posedge g_sel)  c_sel++;
  always @(posedge g_none) c_none++;
  always @(posedge g_hw)   c_hw++;
  always @(posedge g_sw)   c_sw++;
  always @(posedge g_hwon) c_hwon++;

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [31:0] d);
    @(negedge clk); we = 1'b1; wdata = d;
    @(negedge clk); we = 1'b0;
    repeat (2) @(negedge clk);
  endtask

  task automatic set_hw(input logic v);
    @(negedge clk); hw_req = v;
    repeat (3) @(negedge clk);
  endtask

  // pulses of each gated clock over four source cycles
  task automatic count4(output int p_sel, output int p_none, output int p_hw,
                        output int p_sw, output int p_hwon);
    int s0, s1, s2, s3, s4;
    s0 = c_sel; s1 = c_none; s2 = c_hw; s3 = c_sw; s4 = c_hwon;
    repeat (4) @(negedge clk);
    p_sel = c_sel - s0; p_none = c_none - s1; p_hw = c_hw - s2;
    p_sw = c_sw - s3; p_hwon = c_hwon - s4;
  endtask

  initial begin
    #(PERIOD * 200000);
    n_err++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("  CHECKS %0d ERRORS %0d", n_chk, n_err);
    $finish;
  end

  initial begin
    int a, b, c, d, e;
    // R6: reset values while held in reset
    repeat (2) @(negedge clk);
    chk("R6 sel reset", rd_sel, 32'd3);
    chk("R6 sw reset", rd_sw, 32'd1);
    chk("R6 hwon reset", rd_hwon, 32'd0);
    @(negedge clk); rst_n = 1'b1;
    repeat (3) @(negedge clk);
    count4(a, b, c, d, e);
    chk("R6 sel open after reset", a, 4);
    chk("R6 sw open after reset", d, 4);
    chk("R6 sel status", rd_sel, 32'd7);
    chk("R6 sw status", rd_sw, 32'd5);
    chk("R1 none runs", b, 4);
    chk("R1 none reads 0", rd_none, 32'd0);
    chk("R2 hw closed reset", c, 0);
    chk("R2 hw reads 0", rd_hw, 32'd0);
    chk("R5 hwon closed reset", e, 0);

    // R4: selectable kind, table walk
    for (int i = 0; i < NVEC; i++) begin
      @(negedge clk); we = 1'b1; wdata = VEC[i][36:5]; hw_req = VEC[i][4];
      @(negedge clk); we = 1'b0;
      repeat (2) @(negedge clk);
      chk($sformatf("R4 vec %0d rdata", i), rd_sel, {29'd0, VEC[i][3:1]});
      count4(a, b, c, d, e);
      chk($sformatf("R4 vec %0d pulses", i), a, VEC[i][0] ? 4 : 0);
    end

    // R1 / R8: ungated kind after all-ones writes
    chk("R8 none dead bits", rd_none, 32'd0);

    // R2: hardware-only
    set_hw(1'b1);
    count4(a, b, c, d, e);
    chk("R2 hw open", c, 4);
    chk("R2 hw status", rd_hw, 32'd4);
    set_hw(1'b0);
    count4(a, b, c, d, e);
    chk("R2 hw closed", c, 0);
    chk("R2 hw status off", rd_hw, 32'd0);
    chk("R1 none still runs", b, 4);

    // R3 / R8: software-only
    wr(32'hFFFF_FFFE);
    count4(a, b, c, d, e);
    chk("R3 sw closed", d, 0);
    chk("R3 sw rdata", rd_sw, 32'd0);
    set_hw(1'b1);
    count4(a, b, c, d, e);
    chk("R3 sw ignores demand", d, 0);
    set_hw(1'b0);
    wr(32'hFFFF_FFFF);
    count4(a, b, c, d, e);
    chk("R3 sw open", d, 4);
    chk("R8 sw dead bits", rd_sw, 32'd5);

    // R7: status lag after an opening write on software-only
    wr(32'd0);
    @(negedge clk); we = 1'b1; wdata = 32'd1;
    @(negedge clk); we = 1'b0;
    chk("R7 lag edge1", rd_sw, 32'd1);
    @(negedge clk);
    chk("R7 lag edge2", rd_sw, 32'd1);
    @(negedge clk);
    chk("R7 lag edge3", rd_sw, 32'd5);

    // R5: hardware-or-forced-on
    wr(32'd2);
    count4(a, b, c, d, e);
    chk("R5 forced open", e, 4);
    chk("R5 rdata", rd_hwon, 32'd6);
    wr(32'd3);
    chk("R8 hwon no enable bit", rd_hwon, 32'd6);
    wr(32'd0);
    count4(a, b, c, d, e);
    chk("R5 hw owner closed", e, 0);
    set_hw(1'b1);
    count4(a, b, c, d, e);
    chk("R5 hw owner open", e, 4);
    chk("R5 status", rd_hwon, 32'd4);

    $display("  CHECKS %0d ERRORS %0d", n_chk, n_err);
    $finish;
  end

endmodule